// File: doc/BRIEF.md
# Four-beat burst address sequencer

The sequencer supplies the address for each beat of a four-beat burst into a pipelined memory. A load strobe captures a full external address. That address is the first beat. Each later beat keeps the captured upper bits and replaces only the two least significant bits with a value worked out from the captured low pair and a two-bit beat position. A static mode input picks one of two orders. The interleaved order XORs the start with the beat position. The linear order adds the beat position to the start, modulo four. After the fourth beat the sequence comes back to the start address.

The beat position is held in a four-state machine. The states are BEAT_FIRST, BEAT_SECOND, BEAT_THIRD and BEAT_FOURTH, encoded 00, 01, 10 and 11.
- A load moves the machine from any state to BEAT_FIRST. A load overrides an advance in the same cycle.
- An advance with no load moves it one step: BEAT_FIRST to BEAT_SECOND, BEAT_SECOND to BEAT_THIRD, BEAT_THIRD to BEAT_FOURTH, and BEAT_FOURTH back to BEAT_FIRST, which is the wrap.
- With neither a load nor an advance, the machine stays in its current state.

Reset puts the machine in BEAT_FIRST and clears the captured address. The output is combinational from these registers, so it changes in the cycle after the clock edge that loads or advances.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and after it is released until the first load, addr_o is all zeros.
- R2: A rising edge with load_i high captures addr_i, and addr_o equals that value in the following cycle.
- R3: Bits ADDR_W-1 down to 2 of addr_o keep the last loaded value through every advance and hold, whatever addr_i does.
- R4: With mode_i high (interleaved), the low pair of addr_o at beat position k (0 to 3) equals start XOR k. For example, start 01 gives 01, 00, 11, 10.
- R5: With mode_i low (linear), the low pair of addr_o at beat position k equals (start + k) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R6: A fourth advance after a load brings the low pair back to the loaded start.
- R7: A rising edge with load_i low and adv_n_i high leaves addr_o unchanged.
- R8: load_i high on an edge takes precedence over adv_n_i low. The beat position restarts at 0, including when the load comes in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Captures addr_i and restarts the burst |
| adv_n_i | input | 1 | Active-low advance to the next beat |
| mode_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Address of the current beat |

## Verification
The bench builds the sequencer with ADDR_W set to 8. With eight bits, six upper bits pass through beside the generated pair, so a change in the pass-through bits is visible in every expected value written in hex. Driving addr_i to 0xFF on rows that do not load shows that the upper bits come only from the capture. Every one of the four start values is walked in at least one order, including a full wrap in each mode.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Number of address bits generated internally per burst
    localparam int LOW_W = 2;

    // Beat position in the burst; encoding equals the beat offset
    typedef enum logic [LOW_W-1:0] {
        BEAT_FIRST  = 2'b00,
        BEAT_SECOND = 2'b01,
        BEAT_THIRD  = 2'b10,
        BEAT_FOURTH = 2'b11
    } beat_state_t;

    // Order selection as seen on the mode input
    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_mode_t;

endpackage

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_n_i,
    output beat_state_t      state_o,
    output logic [LOW_W-1:0] offset_o
);

    beat_state_t state_q;
    beat_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BEAT_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: load restarts, advance steps, otherwise hold
    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d = BEAT_FIRST;
        end else if (!adv_n_i) begin
            unique case (state_q)
                BEAT_FIRST:  state_d = BEAT_SECOND;
                BEAT_SECOND: state_d = BEAT_THIRD;
                BEAT_THIRD:  state_d = BEAT_FOURTH;
                BEAT_FOURTH: state_d = BEAT_FIRST;
                default:     state_d = BEAT_FIRST;
            endcase
        end
    end

    // Outputs: beat offset applied to the start pair
    always_comb begin
        unique case (state_q)
            BEAT_FIRST:  offset_o = 2'd0;
            BEAT_SECOND: offset_o = 2'd1;
            BEAT_THIRD:  offset_o = 2'd2;
            BEAT_FOURTH: offset_o = 2'd3;
            default:     offset_o = 2'd0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] start_o
);

    logic [ADDR_W-1:0] start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (load_i) begin
            start_q <= addr_i;
        end
    end

    assign start_o = start_q;

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
(
    input  logic             mode_i,
    input  logic [LOW_W-1:0] start_i,
    input  logic [LOW_W-1:0] offset_i,
    output logic [LOW_W-1:0] low_o
);

    logic [LOW_W-1:0] lin_low;
    logic [LOW_W-1:0] ilv_low;

    // Linear: modulo-4 count from the start
    assign lin_low = start_i + offset_i;
    // Interleaved: offset flips start bits
    assign ilv_low = start_i ^ offset_i;

    always_comb begin
        unique case (order_mode_t'(mode_i))
            ORDER_INTERLEAVED: low_o = ilv_low;
            ORDER_LINEAR:      low_o = lin_low;
            default:           low_o = ilv_low;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic              mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UP_W = ADDR_W - LOW_W;

    beat_state_t      beat_state;
    logic [LOW_W-1:0] beat_offset;
    logic [ADDR_W-1:0] start_addr;
    logic [LOW_W-1:0] gen_low;

    burst_beat_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .adv_n_i  (adv_n_i),
        .state_o  (beat_state),
        .offset_o (beat_offset)
    );

    burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .addr_i  (addr_i),
        .start_o (start_addr)
    );

    burst_order_map u_map (
        .mode_i   (mode_i),
        .start_i  (start_addr[LOW_W-1:0]),
        .offset_i (beat_offset),
        .low_o    (gen_low)
    );

    // Upper bits pass through from the capture; low pair is generated
    assign addr_o = {start_addr[ADDR_W-1 -: UP_W], gen_low};

    logic unused_state;
    assign unused_state = ^beat_state;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              adv_n_i,
    input logic              mode_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o
);

    logic       armed_q;
    logic [1:0] start_q;
    logic [1:0] cnt_q;
    logic [1:0] lin_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            start_q <= 2'b00;
            cnt_q   <= 2'b00;
        end else if (load_i) begin
            armed_q <= 1'b1;
            start_q <= addr_i[1:0];
            cnt_q   <= 2'b00;
        end else if (!adv_n_i) begin
            cnt_q   <= cnt_q + 2'b01;
        end
    end

    assign lin_exp = start_q + cnt_q;

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(addr_i));

    // R3
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

    // R4
    interleave_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && mode_i) |-> addr_o[1:0] == (start_q ^ cnt_q));

    // R5
    linear_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !mode_i) |-> addr_o[1:0] == lin_exp);

    // R6
    wrap_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && cnt_q == 2'b00) |-> addr_o[1:0] == start_q);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(addr_o));

    // R8
    load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !adv_n_i) |=> addr_o[1:0] == $past(addr_i[1:0]));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .adv_n_i (adv_n_i),
    .mode_i  (mode_i),
    .addr_i  (addr_i),
    .addr_o  (addr_o)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;

    localparam int AW = 8;
    localparam int NV = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic          adv_n_i = 1'b1;
    logic          mode_i = 1'b1;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_n_i (adv_n_i),
        .mode_i  (mode_i),
        .addr_i  (addr_i),
        .addr_o  (addr_o)
    );

    // {load, adv_n, mode, addr_in, expected addr_o after the edge}
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b1, 8'hA5, 8'hA5},  // interleaved, start 01
        {1'b0, 1'b0, 1'b1, 8'hFF, 8'hA4},
        {1'b0, 1'b0, 1'b1, 8'hFF, 8'hA7},
        {1'b0, 1'b0, 1'b1, 8'hFF, 8'hA6},
        {1'b0, 1'b0, 1'b1, 8'hFF, 8'hA5},  // wrap
        {1'b0, 1'b1, 1'b1, 8'hFF, 8'hA5},  // hold
        {1'b1, 1'b1, 1'b0, 8'h3E, 8'h3E},  // linear, start 10
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h3F},
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h3C},
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h3D},
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h3E},  // wrap
        {1'b1, 1'b0, 1'b0, 8'h53, 8'h53},  // load wins over advance
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h50},
        {1'b0, 1'b1, 1'b0, 8'h00, 8'h50},  // hold
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h51},
        {1'b1, 1'b1, 1'b1, 8'hC3, 8'hC3},  // interleaved, start 11
        {1'b0, 1'b0, 1'b1, 8'h00, 8'hC2},
        {1'b0, 1'b0, 1'b1, 8'h00, 8'hC1},
        {1'b0, 1'b0, 1'b1, 8'h00, 8'hC0},
        {1'b0, 1'b0, 1'b1, 8'h00, 8'hC3},  // wrap
        {1'b1, 1'b1, 1'b1, 8'h10, 8'h10},  // interleaved, start 00
        {1'b0, 1'b0, 1'b1, 8'hFF, 8'h11},
        {1'b0, 1'b0, 1'b1, 8'hFF, 8'h12},
        {1'b1, 1'b0, 1'b1, 8'h6A, 8'h6A},  // reload mid-burst
        {1'b0, 1'b0, 1'b1, 8'hFF, 8'h6B},
        {1'b1, 1'b1, 1'b0, 8'h81, 8'h81},  // linear, start 01
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h82},
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h83},
        {1'b0, 1'b1, 1'b0, 8'hFF, 8'h83},  // hold
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h80},
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h81},  // wrap
        {1'b0, 1'b1, 1'b0, 8'h5A, 8'h81}   // hold
    };

    task automatic check(input string tag, input logic [AW-1:0] exp);
        n_cmp++;
        if (addr_o !== exp) begin
            n_bad++;
            $display("FAIL %s: addr_o=%02h expected=%02h", tag, addr_o, exp);
        end
    endtask

    // One clock: inputs already set at negedge, sample at the next negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int adv_cnt;
        string tag;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset low", 8'h00);
        rst_n = 1'b1;
        step();
        check("R1 after release", 8'h00);

        adv_cnt = 0;
        for (int i = 0; i < NV; i++) begin
            load_i  = VEC[i][18];
            adv_n_i = VEC[i][17];
            mode_i  = VEC[i][16];
            addr_i  = VEC[i][15:8];
            if (VEC[i][18]) begin
                adv_cnt = 0;
                tag = VEC[i][17] ? "R2 load" : "R8 load over advance";
            end else if (VEC[i][17]) begin
                tag = "R7 hold";
            end else begin
                adv_cnt++;
                if (adv_cnt == 4)      tag = "R6 wrap";
                else if (VEC[i][16])   tag = "R4 interleaved";
                else                   tag = "R5 linear";
            end
            step();
            check(tag, VEC[i][7:0]);
        end

        // R3: upper bits ignore addr_i toggling across a full burst
        load_i = 1'b1; adv_n_i = 1'b1; mode_i = 1'b0; addr_i = 8'h96;
        step();
        load_i = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            addr_i  = (k % 2 == 1) ? 8'h00 : 8'hFF;
            adv_n_i = 1'b0;
            step();
            check("R3 upper bits", {6'b100101, 2'(2'b10 + 2'(k))});
        end

        // R1: reset during a burst
        adv_n_i = 1'b0;
        step();
        rst_n = 1'b0;
        #1;
        check("R1 async reset", 8'h00);
        step();
        rst_n = 1'b1;
        adv_n_i = 1'b1;
        step();
        check("R1 cleared", 8'h00);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule